// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block is a synchronous controller that writes one byte at a time into a 32K x 8 ultraviolet-erasable EPROM and then confirms the write. A host raises a one-cycle start strobe with a 15-bit address and an 8-bit byte. The sequencer then asks the external supplies for the raised programming voltage and, after its settling time, for the raised core voltage. It drives the byte onto the device data pins, applies a chip-enable pulse of fixed width, and releases the bus. It then enables the device outputs to read the byte back. Every interval is a parameter counted in clock cycles.

If the byte read back differs from the one written, the program pulse and read-back are repeated, up to a parameterised total number of pulses. When the sequence ends, both supply requests drop, both device strobes return high, and `done` pulses for one clock. `fail` pulses alongside `done` if the last read-back did not match. The data pins are split into an output, an output enable and an input. The pad ring joins them into one bidirectional bus.

Top module: `eprom_prog_seq`

## Requirements
- R1: After a synchronous active-low reset, dev_ce_n and dev_oe_n are 1, vpp_hi_req, vcc_hi_req, dev_data_oe, busy, done and fail are 0.
- R2: An accepted start raises vpp_hi_req (and busy) one cycle later; vcc_hi_req rises exactly T_VPS cycles after vpp_hi_req; dev_data_oe first rises exactly T_VCS cycles after vcc_hi_req; vcc_hi_req is never high without vpp_hi_req.
- R3: A program pulse is dev_ce_n low for exactly T_PW cycles, during which dev_oe_n is 1, both supply requests are 1, dev_data_oe is 1 and dev_data_out equals the host byte.
- R4: dev_data_oe rises exactly max(T_AS,T_DS) cycles before dev_ce_n falls and falls exactly T_DH cycles after dev_ce_n rises; dev_addr equals the accepted address for every cycle busy is high.
- R5: Read-back is dev_oe_n low for exactly T_OE cycles with dev_ce_n 1 and both supply requests 1; dev_oe_n falls exactly one cycle after dev_data_oe falls; the byte is sampled at the end of the last low cycle.
- R6: dev_data_oe is never 1 while dev_oe_n is 0.
- R7: After dev_oe_n rises, exactly T_DF cycles pass before dev_data_oe rises again or done is raised.
- R8: On a read-back mismatch the pulse and read-back pair is repeated; the total number of pulses in one operation is at most MAX_PULSES, and the sequence stops at the first match.
- R9: done is high for exactly one cycle per operation; in that cycle busy is 0, both supply requests are 0 and dev_ce_n and dev_oe_n are 1.
- R10: fail is high only in the done cycle, and only when the last read-back differed from the host byte.
- R11: A start while busy is ignored: the address and byte in use are unchanged and no further operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to program a byte |
| addr_in | input | 15 | Target byte address |
| wdata | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | One-cycle failure flag, coincident with done |
| dev_addr | output | 15 | Device address pins |
| dev_data_out | output | 8 | Byte driven toward the device data pins |
| dev_data_oe | output | 1 | Drive enable for the device data pins |
| dev_data_in | input | 8 | Byte seen on the device data pins |
| dev_ce_n | output | 1 | Device chip enable, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| vpp_hi_req | output | 1 | Request for the raised programming supply |
| vcc_hi_req | output | 1 | Request for the raised core supply |

## Verification
The retry path is the hardest to reach from the ports, because a real device takes a byte on the first pulse. The bench's device model therefore takes a configurable number of pulses before a write sticks. It also models the one-way nature of the cells: a second write can only clear bits. This lets the stimulus reach a success on the last permitted pulse, a failure after the limit, and a byte that can never verify. The model drives the complement of the stored byte until output enable has been low for the read-back time, so a sample taken one cycle early is caught.

// File: rtl/eprom_prog_pkg.sv
// Package: shared state and pin-control types for the EPROM byte programmer.
// Assumes: one state per programming phase; pin levels depend only on state.
package eprom_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VPP_UP,
        ST_VCC_UP,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RELEASE,
        ST_VERIFY,
        ST_FLOAT
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic vpp_hi;
        logic vcc_hi;
        logic drive;
    } pin_ctl_t;

    // Device pin levels for each phase of the sequence.
    function automatic pin_ctl_t decode_pins(seq_state_t s);
        pin_ctl_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, vpp_hi: 1'b1, vcc_hi: 1'b1, drive: 1'b0};
        unique case (s)
            ST_IDLE:    begin p.vpp_hi = 1'b0; p.vcc_hi = 1'b0; end
            ST_VPP_UP:  p.vcc_hi = 1'b0;
            ST_VCC_UP:  ;
            ST_SETUP:   p.drive = 1'b1;
            ST_PULSE:   begin p.drive = 1'b1; p.ce_n = 1'b0; end
            ST_HOLD:    p.drive = 1'b1;
            ST_RELEASE: ;
            ST_VERIFY:  p.oe_n = 1'b0;
            ST_FLOAT:   ;
            default:    begin p.vpp_hi = 1'b0; p.vcc_hi = 1'b0; end
        endcase
        return p;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_interval_timer.sv
// Module: down-counting interval timer for the programming phases.
// Assumes: load_val >= 1; after a load, expired rises in the load_val-th cycle.
module eprom_interval_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Count down from the loaded length, resting at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - CW'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign expired = (cnt_q == '0);

    // Every phase lasts at least one cycle.
    nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/eprom_pin_encoder.sv
// Module: registers the device strobes, supply requests and bus enable.
// Assumes: fed with the next state, so the pins match the current state
// and change only at clock edges, without glitches.
module eprom_pin_encoder
    import eprom_prog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t next_state,
    output pin_ctl_t   pins
);

    // Latch the pin levels of the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pins <= decode_pins(ST_IDLE);
        else
            pins <= decode_pins(next_state);
    end

endmodule

// File: rtl/eprom_prog_seq.sv
// Module: top-level byte programming sequencer for a 32K x 8 EPROM.
// Assumes: all T_* intervals are >= 1 clock cycle; the pad ring merges
// dev_data_out/dev_data_oe/dev_data_in into one bidirectional bus.
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 15,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned T_VPS      = 250,
    parameter int unsigned T_VCS      = 250,
    parameter int unsigned T_AS       = 250,
    parameter int unsigned T_DS       = 250,
    parameter int unsigned T_PW       = 12500,
    parameter int unsigned T_DH       = 250,
    parameter int unsigned T_OE       = 20,
    parameter int unsigned T_DF       = 16,
    parameter int unsigned MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_data_out,
    output logic              dev_data_oe,
    input  logic [DATA_W-1:0] dev_data_in,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    output logic              vpp_hi_req,
    output logic              vcc_hi_req
);

    localparam int unsigned T_SETUP = max_u(T_AS, T_DS);
    localparam int unsigned T_LONG  = max_u(max_u(max_u(T_VPS, T_VCS), max_u(T_SETUP, T_PW)),
                                            max_u(max_u(T_DH, T_OE), T_DF));
    localparam int unsigned CW      = $clog2(T_LONG + 1);
    localparam int unsigned PCW     = $clog2(MAX_PULSES + 1);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, rd_q;
    logic [PCW-1:0]    pulses_q;
    logic              done_q, fail_q;
    logic              tmr_load, tmr_expired;
    logic [CW-1:0]     tmr_len;
    logic              accept, byte_ok, last_try, finish;
    pin_ctl_t          pins;

    // Length in cycles of each timed phase.
    function automatic logic [CW-1:0] phase_len(seq_state_t s);
        unique case (s)
            ST_VPP_UP: return CW'(T_VPS);
            ST_VCC_UP: return CW'(T_VCS);
            ST_SETUP:  return CW'(T_SETUP);
            ST_PULSE:  return CW'(T_PW);
            ST_HOLD:   return CW'(T_DH);
            ST_VERIFY: return CW'(T_OE);
            ST_FLOAT:  return CW'(T_DF);
            default:   return CW'(1);
        endcase
    endfunction

    assign accept   = (state_q == ST_IDLE) && start;
    assign byte_ok  = (rd_q == data_q);
    assign last_try = (pulses_q == PCW'(MAX_PULSES));

    // Next-state selection through the programming phases.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)       state_d = ST_VPP_UP;
            ST_VPP_UP:  if (tmr_expired) state_d = ST_VCC_UP;
            ST_VCC_UP:  if (tmr_expired) state_d = ST_SETUP;
            ST_SETUP:   if (tmr_expired) state_d = ST_PULSE;
            ST_PULSE:   if (tmr_expired) state_d = ST_HOLD;
            ST_HOLD:    if (tmr_expired) state_d = ST_RELEASE;
            ST_RELEASE: if (tmr_expired) state_d = ST_VERIFY;
            ST_VERIFY:  if (tmr_expired) state_d = ST_FLOAT;
            ST_FLOAT:   if (tmr_expired) state_d = (byte_ok || last_try) ? ST_IDLE : ST_SETUP;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign finish   = (state_q == ST_FLOAT) && tmr_expired && (state_d == ST_IDLE);
    assign tmr_load = (state_d != state_q) && (state_d != ST_IDLE);
    assign tmr_len  = phase_len(state_d);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the host request when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= addr_in;
            data_q <= wdata;
        end
    end

    // Count program pulses issued in the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulses_q <= '0;
        else if (accept)
            pulses_q <= '0;
        else if ((state_d == ST_PULSE) && (state_q != ST_PULSE))
            pulses_q <= pulses_q + PCW'(1);
    end

    // Sample the read-back byte at the end of the last output-enable cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if ((state_q == ST_VERIFY) && tmr_expired)
            rd_q <= dev_data_in;
    end

    // Completion and failure flags, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= finish;
            fail_q <= finish && !byte_ok;
        end
    end

    eprom_interval_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_len),
        .expired  (tmr_expired)
    );

    eprom_pin_encoder u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (state_d),
        .pins       (pins)
    );

    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;
    assign fail         = fail_q;
    assign dev_addr     = addr_q;
    assign dev_data_out = data_q;
    assign dev_data_oe  = pins.drive;
    assign dev_ce_n     = pins.ce_n;
    assign dev_oe_n     = pins.oe_n;
    assign vpp_hi_req   = pins.vpp_hi;
    assign vcc_hi_req   = pins.vcc_hi;

    // R2
    vcc_after_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_hi_req |-> vpp_hi_req);
    // R3
    pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_ce_n |-> (dev_oe_n && vpp_hi_req && vcc_hi_req && dev_data_oe));
    // R5
    verify_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> (dev_ce_n && vpp_hi_req && vcc_hi_req));
    // R5
    release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_oe_n) |-> !$past(dev_data_oe));
    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_data_oe |-> dev_oe_n);
    // R8
    pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= PCW'(MAX_PULSES));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !vpp_hi_req && !vcc_hi_req && dev_ce_n && dev_oe_n));
    // R10
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);
    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dev_addr) && $stable(dev_data_out)));

endmodule

// File: tb/test_eprom_prog_seq.sv
module test_eprom_prog_seq;

    localparam int T_VPS = 2, T_VCS = 3, T_AS = 2, T_DS = 4, T_PW = 3;
    localparam int T_DH = 2, T_OE = 3, T_DF = 2, MAXP = 3;
    localparam int T_SET = (T_AS > T_DS) ? T_AS : T_DS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] addr_in = '0;
    logic [7:0]  wdata = '0;
    logic        busy, done, fail;
    logic [14:0] dev_addr;
    logic [7:0]  dev_data_out, dev_data_in;
    logic        dev_data_oe, dev_ce_n, dev_oe_n, vpp_hi_req, vcc_hi_req;

    int checks = 0, errors = 0, cyc = 0;
    int need_pulses = 1;
    int pulses_seen = 0;
    int oe_lo_cnt = 0, ce_lo_cnt = 0;
    logic [7:0] lat_data = '0;
    logic erase_req = 1'b0;
    logic [7:0] mem [0:32767];
    logic [14:0] cur_addr = '0;
    logic [7:0]  cur_data = '0;
    int contention_hits = 0, addr_bad = 0;

    eprom_prog_seq #(
        .T_VPS(T_VPS), .T_VCS(T_VCS), .T_AS(T_AS), .T_DS(T_DS), .T_PW(T_PW),
        .T_DH(T_DH), .T_OE(T_OE), .T_DF(T_DF), .MAX_PULSES(MAXP)
    ) i_eprom_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .wdata(wdata),
        .busy(busy), .done(done), .fail(fail), .dev_addr(dev_addr),
        .dev_data_out(dev_data_out), .dev_data_oe(dev_data_oe), .dev_data_in(dev_data_in),
        .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .vpp_hi_req(vpp_hi_req), .vcc_hi_req(vcc_hi_req)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Device model: one-way cells, slow read-back, configurable pulses per write.
    always @(posedge clk) begin
        if (erase_req) begin
            for (int i = 0; i < 32768; i++) mem[i] <= 8'hFF;
        end
        if (dev_oe_n) oe_lo_cnt <= 0;
        else          oe_lo_cnt <= oe_lo_cnt + 1;
        if (rst_n && start && !busy) pulses_seen <= 0;
        if (!dev_ce_n && dev_oe_n && vpp_hi_req && vcc_hi_req && dev_data_oe) begin
            ce_lo_cnt <= ce_lo_cnt + 1;
            lat_data  <= dev_data_out;
        end else if (dev_ce_n && ce_lo_cnt != 0) begin
            ce_lo_cnt <= 0;
            if (ce_lo_cnt >= T_PW) begin
                pulses_seen <= pulses_seen + 1;
                if (pulses_seen + 1 >= need_pulses)
                    mem[dev_addr] <= mem[dev_addr] & lat_data;
            end
        end
    end

    always_comb begin
        if (dev_oe_n)                    dev_data_in = 8'h00;
        else if (oe_lo_cnt >= T_OE - 1)  dev_data_in = mem[dev_addr];
        else                             dev_data_in = ~mem[dev_addr];
    end

    // Pin-timing monitor, sampled away from the active edge.
    logic p_vpp = 0, p_vcc = 0, p_doe = 0, p_ce = 1, p_oe = 1;
    int t_vpp = 0, t_vcc = 0, t_doe_r = 0, t_ce_f = 0, t_ce_r = 0, t_doe_f = 0, t_oe_f = 0, t_oe_r = 0;
    bit first_drive = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (vpp_hi_req && !p_vpp) begin t_vpp = cyc; first_drive = 1; end
            if (vcc_hi_req && !p_vcc) begin
                chk(cyc - t_vpp == T_VPS, "R2 vpp-to-vcc", cyc - t_vpp, T_VPS);
                t_vcc = cyc;
            end
            if (dev_data_oe && !p_doe) begin
                if (first_drive) chk(cyc - t_vcc == T_VCS, "R2 vcc-to-drive", cyc - t_vcc, T_VCS);
                else             chk(cyc - t_oe_r == T_DF, "R7 float-before-redrive", cyc - t_oe_r, T_DF);
                first_drive = 0;
                t_doe_r = cyc;
            end
            if (!dev_ce_n && p_ce) begin
                chk(cyc - t_doe_r == T_SET, "R4 data setup", cyc - t_doe_r, T_SET);
                chk(vpp_hi_req && vcc_hi_req && dev_oe_n && dev_data_oe && dev_data_out == cur_data,
                    "R3 program mode", dev_data_out, cur_data);
                t_ce_f = cyc;
            end
            if (dev_ce_n && !p_ce) begin
                chk(cyc - t_ce_f == T_PW, "R3 pulse width", cyc - t_ce_f, T_PW);
                t_ce_r = cyc;
            end
            if (!dev_data_oe && p_doe) begin
                chk(cyc - t_ce_r == T_DH, "R4 data hold", cyc - t_ce_r, T_DH);
                t_doe_f = cyc;
            end
            if (!dev_oe_n && p_oe) begin
                chk(cyc - t_doe_f == 1 && dev_ce_n && vpp_hi_req && vcc_hi_req,
                    "R5 release then verify", cyc - t_doe_f, 1);
                t_oe_f = cyc;
            end
            if (dev_oe_n && !p_oe) begin
                chk(cyc - t_oe_f == T_OE, "R5 read-back width", cyc - t_oe_f, T_OE);
                t_oe_r = cyc;
            end
            if (done) begin
                chk(cyc - t_oe_r == T_DF, "R7 float-before-done", cyc - t_oe_r, T_DF);
                chk(!busy && !vpp_hi_req && !vcc_hi_req && dev_ce_n && dev_oe_n,
                    "R9 idle pins at done", {busy, vpp_hi_req, vcc_hi_req, dev_ce_n, dev_oe_n}, 5'b00011);
            end
            if (dev_data_oe && !dev_oe_n) contention_hits++;
            if (busy && dev_addr != cur_addr) addr_bad++;
        end
        p_vpp = vpp_hi_req; p_vcc = vcc_hi_req; p_doe = dev_data_oe;
        p_ce = dev_ce_n; p_oe = dev_oe_n;
    end

    // Run one operation and check its outcome.
    task automatic program_byte(input logic [14:0] a, input logic [7:0] d, input int need,
                                input bit exp_fail, input int exp_pulses, input logic [7:0] exp_mem);
        int wait_cyc;
        need_pulses = need;
        cur_addr = a;
        cur_data = d;
        @(negedge clk);
        start = 1'b1; addr_in = a; wdata = d;
        @(negedge clk);
        start = 1'b0;
        chk(busy && vpp_hi_req && !vcc_hi_req, "R2 start raises vpp", {busy, vpp_hi_req, vcc_hi_req}, 3'b110);
        wait_cyc = 0;
        while (!done && wait_cyc < 500) begin
            chk(!fail, "R10 fail only with done", fail, 0);
            @(negedge clk);
            wait_cyc++;
        end
        chk(done, "R9 done reached", done, 1);
        chk(fail == exp_fail, "R10 fail flag", fail, exp_fail);
        chk(pulses_seen == exp_pulses, "R8 pulse count", pulses_seen, exp_pulses);
        chk(mem[a] == exp_mem, "R3 stored byte", mem[a], exp_mem);
        @(negedge clk);
        chk(!done && !fail, "R9 done one cycle", {done, fail}, 0);
    endtask

    initial begin : main
        erase_req = 1'b1;
        repeat (5) @(negedge clk);
        erase_req = 1'b0;
        // R1 reset state
        chk(dev_ce_n && dev_oe_n && !vpp_hi_req && !vcc_hi_req && !dev_data_oe && !busy && !done && !fail,
            "R1 reset state",
            {dev_ce_n, dev_oe_n, vpp_hi_req, vcc_hi_req, dev_data_oe, busy, done, fail}, 8'b11000000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dev_ce_n && dev_oe_n && !busy, "R1 idle after reset", {dev_ce_n, dev_oe_n, busy}, 3'b110);

        // Sweep every byte value into distinct erased addresses.
        for (int d = 0; d < 256; d++) begin
            logic [14:0] a;
            a = 15'((d * 131 + 7) % 32768);
            program_byte(a, 8'(d), 1, 1'b0, 1, 8'(d));
        end

        // R8 retries: success on second and on last permitted pulse.
        program_byte(15'h7FFF, 8'h5A, 2, 1'b0, 2, 8'h5A);
        program_byte(15'h7FFE, 8'hA5, MAXP, 1'b0, MAXP, 8'hA5);
        // R8/R10: the byte never takes within the limit.
        program_byte(15'h7FFD, 8'h3C, MAXP + 1, 1'b1, MAXP, 8'hFF);
        // R10: cells cannot return to 1, so a second write can never verify.
        program_byte(15'h7FFC, 8'hF0, 1, 1'b0, 1, 8'hF0);
        program_byte(15'h7FFC, 8'h0F, 1, 1'b1, MAXP, 8'h00);

        // R11: a start while busy is ignored.
        need_pulses = 1;
        cur_addr = 15'h7FFB; cur_data = 8'h66;
        @(negedge clk);
        start = 1'b1; addr_in = 15'h7FFB; wdata = 8'h66;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        start = 1'b1; addr_in = 15'h0000; wdata = 8'h00;
        @(negedge clk);
        start = 1'b0;
        begin
            int w;
            w = 0;
            while (!done && w < 500) begin @(negedge clk); w++; end
        end
        chk(done && !fail, "R11 first operation completes", {done, fail}, 2'b10);
        repeat (40) begin
            @(negedge clk);
            chk(!busy, "R11 no second operation", busy, 0);
        end
        chk(mem[15'h7FFB] == 8'h66, "R11 first byte stored", mem[15'h7FFB], 8'h66);
        chk(mem[15'h0000] == 8'hFF, "R11 ignored address untouched", mem[15'h0000], 8'hFF);

        chk(contention_hits == 0, "R6 no drive while outputs enabled", contention_hits, 0);
        chk(addr_bad == 0, "R4 address held while busy", addr_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule